// File: doc/BRIEF.md
# Type-Gated Additive Word Scrambler Pair

This block holds two identical 32-bit word lanes: one whitens words before they go onto a serial link, the other restores them at the far end. Every word carries a 2-bit type code. Only words typed as payload are combined with a pseudo-random keystream from a 7-bit linear feedback register. Marker words and a fixed idle pattern restart the register at both ends, so the two ends stay in step without a separate frame pulse.

A shared enable turns whitening off when the link already has enough edge transitions. Each lane has one register stage. The word, its type and its strobe come out together one cycle after they go in. Serialization, clock recovery and word alignment are handled outside the block. In normal use the transmit lane's outputs feed the receive lane's inputs through the link.

Top module: `wscr_link`

## Requirements
- R1: With `scram_en` high, a valid word whose type is 2'b01 or 2'b10 leaves the lane as the input word XOR the current 32-bit keystream word, and the register advances 32 steps.
- R2: One keystream step takes the 7-bit state s[6:0], emits s[6] as the keystream bit, and then loads {s[5:0], s[6]^s[0]}. This is the recurrence k[n] = k[n-1] ^ k[n-7] of the 1 + x + x^7 family. Word bit 31 takes the first bit emitted and bit 0 takes the 32nd.
- R3: A valid word of type 2'b11 (request, header or cell marker) passes through unchanged and reloads the state with all ones. The next payload word uses the keystream that starts from that seed.
- R4: A valid type 2'b00 word equal to `IDLE_WORD` (default 32'hA5C33C5A) also reloads the all-ones seed. Any other type 2'b00 word leaves the state as it was, so the sequence continues across it.
- R5: Words of type 2'b00 or 2'b11 are never modified.
- R6: With `scram_en` low, every word passes through unmodified and payload words do not advance the state. Reseeding words still reload the seed.
- R7: The output strobe, type and word appear exactly one clock after the input, and the type stays aligned with its word.
- R8: In a cycle with the input strobe low, the output strobe is low in the next cycle, the output word and type hold their values, and the state does not change.
- R9: Reset clears both output strobes and the output words and loads the all-ones seed into both lanes.
- R10: The receive lane applies exactly the same processing. A word stream fed through the transmit lane and then the receive lane comes back bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scram_en | input | 1 | Whitening enable for both lanes |
| tx_valid_i | input | 1 | Transmit lane input strobe |
| tx_type_i | input | 2 | Transmit lane input type code |
| tx_data_i | input | 32 | Transmit lane input word |
| tx_valid_o | output | 1 | Transmit lane output strobe |
| tx_type_o | output | 2 | Transmit lane output type code |
| tx_data_o | output | 32 | Transmit lane whitened word |
| rx_valid_i | input | 1 | Receive lane input strobe |
| rx_type_i | input | 2 | Receive lane input type code |
| rx_data_i | input | 32 | Receive lane whitened word |
| rx_valid_o | output | 1 | Receive lane output strobe |
| rx_type_o | output | 2 | Receive lane output type code |
| rx_data_o | output | 32 | Receive lane restored word |

## Verification
With the lanes chained, the reseed in one lane coincides with the keystream use in the other. In the cycle a marker or idle word reloads the transmit state, the receive lane is descrambling the payload word that came just before it with its own, older state. The bench drives marker, idle and non-idle control words back-to-back with payload words in random mixes, so that this overlap occurs in many cycles. It judges the result in two ways: the receive output must equal the original word, and the transmit output must equal a bit-serial reference keystream.

// File: rtl/wscr_pkg.sv
package wscr_pkg;

    localparam int WORD_W = 32;
    localparam int TYPE_W = 2;
    localparam int LFSR_W = 7;

    typedef logic [TYPE_W-1:0] wtype_t;

    // type codes; the two payload codes are the only ones whitened
    localparam wtype_t TYP_CTRL   = 2'b00;
    localparam wtype_t TYP_DATA_A = 2'b01;
    localparam wtype_t TYP_DATA_B = 2'b10;
    localparam wtype_t TYP_MARK   = 2'b11;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic              vld;
        wtype_t            typ;
        logic [WORD_W-1:0] word;
    } lane_reg_t;

    // keystream word produced from a given state (used by the checker)
    function automatic logic [WORD_W-1:0] keystream_of(input logic [LFSR_W-1:0] s_in);
        logic [LFSR_W-1:0] s;
        logic [WORD_W-1:0] k;
        s = s_in;
        k = '0;
        for (int i = 0; i < WORD_W; i++) begin
            k[WORD_W-1-i] = s[LFSR_W-1];
            s = {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[0]};
        end
        return k;
    endfunction

endpackage

// File: rtl/wscr_keygen.sv
module wscr_keygen
    import wscr_pkg::*;
#(
    parameter int STEPS = WORD_W,
    parameter int SW    = LFSR_W
) (
    input  logic [SW-1:0]    state_i,
    output logic [STEPS-1:0] ks_o,
    output logic [SW-1:0]    next_o
);

    localparam int MSB = SW - 1;

    // unrolled: STEPS serial shifts evaluated in one cycle
    always_comb begin
        logic [SW-1:0] s;
        s    = state_i;
        ks_o = '0;
        for (int i = 0; i < STEPS; i++) begin
            ks_o[STEPS-1-i] = s[MSB];
            s = {s[MSB-1:0], s[MSB] ^ s[0]};
        end
        next_o = s;
    end

endmodule

// File: rtl/wscr_classify.sv
module wscr_classify
    import wscr_pkg::*;
#(
    parameter logic [WORD_W-1:0] IDLE_WORD = 32'hA5C3_3C5A
) (
    input  wtype_t            type_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              is_data_o,
    output logic              is_reseed_o
);

    logic idle_hit;

    assign idle_hit    = (type_i == TYP_CTRL) && (word_i == IDLE_WORD);
    assign is_data_o   = (type_i == TYP_DATA_A) || (type_i == TYP_DATA_B);
    assign is_reseed_o = (type_i == TYP_MARK) || idle_hit;

endmodule

// File: rtl/wscr_lane.sv
module wscr_lane
    import wscr_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED      = '1,
    parameter logic [WORD_W-1:0] IDLE_WORD = 32'hA5C3_3C5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              valid_i,
    input  wtype_t            type_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              valid_o,
    output wtype_t            type_o,
    output logic [WORD_W-1:0] data_o
);

    localparam lane_reg_t RST_VAL = '{lfsr: SEED, vld: 1'b0, typ: TYP_CTRL, word: '0};

    lane_reg_t         q, d;
    logic              is_data, is_reseed;
    logic [WORD_W-1:0] ks;
    logic [LFSR_W-1:0] lfsr_adv;

    wscr_classify #(.IDLE_WORD(IDLE_WORD)) i_classify (
        .type_i     (type_i),
        .word_i     (data_i),
        .is_data_o  (is_data),
        .is_reseed_o(is_reseed)
    );

    wscr_keygen #(.STEPS(WORD_W), .SW(LFSR_W)) i_keygen (
        .state_i(q.lfsr),
        .ks_o   (ks),
        .next_o (lfsr_adv)
    );

    always_comb begin
        d     = q;
        d.vld = valid_i;
        if (valid_i) begin
            d.typ  = type_i;
            d.word = data_i;
            if (is_data && en_i) begin
                d.word = data_i ^ ks;
                d.lfsr = lfsr_adv;
            end else if (is_reseed) begin
                d.lfsr = SEED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.vld;
    assign type_o  = q.typ;
    assign data_o  = q.word;

endmodule

// File: rtl/wscr_link.sv
module wscr_link
    import wscr_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED      = '1,
    parameter logic [WORD_W-1:0] IDLE_WORD = 32'hA5C3_3C5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scram_en,
    input  logic              tx_valid_i,
    input  logic [1:0]        tx_type_i,
    input  logic [31:0]       tx_data_i,
    output logic              tx_valid_o,
    output logic [1:0]        tx_type_o,
    output logic [31:0]       tx_data_o,
    input  logic              rx_valid_i,
    input  logic [1:0]        rx_type_i,
    input  logic [31:0]       rx_data_i,
    output logic              rx_valid_o,
    output logic [1:0]        rx_type_o,
    output logic [31:0]       rx_data_o
);

    localparam int N_LANES = 2;
    localparam int LN_TX   = 0;
    localparam int LN_RX   = 1;

    logic              ln_vld_i [N_LANES];
    wtype_t            ln_typ_i [N_LANES];
    logic [WORD_W-1:0] ln_dat_i [N_LANES];
    logic              ln_vld_o [N_LANES];
    wtype_t            ln_typ_o [N_LANES];
    logic [WORD_W-1:0] ln_dat_o [N_LANES];

    assign ln_vld_i[LN_TX] = tx_valid_i;
    assign ln_typ_i[LN_TX] = tx_type_i;
    assign ln_dat_i[LN_TX] = tx_data_i;
    assign ln_vld_i[LN_RX] = rx_valid_i;
    assign ln_typ_i[LN_RX] = rx_type_i;
    assign ln_dat_i[LN_RX] = rx_data_i;

    // an additive scrambler is its own inverse: both lanes are identical
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        wscr_lane #(.SEED(SEED), .IDLE_WORD(IDLE_WORD)) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (scram_en),
            .valid_i(ln_vld_i[g]),
            .type_i (ln_typ_i[g]),
            .data_i (ln_dat_i[g]),
            .valid_o(ln_vld_o[g]),
            .type_o (ln_typ_o[g]),
            .data_o (ln_dat_o[g])
        );
    end

    assign tx_valid_o = ln_vld_o[LN_TX];
    assign tx_type_o  = ln_typ_o[LN_TX];
    assign tx_data_o  = ln_dat_o[LN_TX];
    assign rx_valid_o = ln_vld_o[LN_RX];
    assign rx_type_o  = ln_typ_o[LN_RX];
    assign rx_data_o  = ln_dat_o[LN_RX];

endmodule

// File: rtl/wscr_link_chk.sv
module wscr_link_chk
    import wscr_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED      = '1,
    parameter logic [WORD_W-1:0] IDLE_WORD = 32'hA5C3_3C5A
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scram_en,
    input logic        tx_valid_i,
    input logic [1:0]  tx_type_i,
    input logic [31:0] tx_data_i,
    input logic        tx_valid_o,
    input logic [1:0]  tx_type_o,
    input logic [31:0] tx_data_o,
    input logic        rx_valid_i,
    input logic [1:0]  rx_type_i,
    input logic [31:0] rx_data_i,
    input logic        rx_valid_o,
    input logic [1:0]  rx_type_o,
    input logic [31:0] rx_data_o
);

    localparam logic [WORD_W-1:0] SEED_KS = keystream_of(SEED);

    logic tx_is_data, tx_ctrl, rx_ctrl, tx_idle;
    assign tx_is_data = (tx_type_i == TYP_DATA_A) || (tx_type_i == TYP_DATA_B);
    assign tx_ctrl    = (tx_type_i == TYP_CTRL) || (tx_type_i == TYP_MARK);
    assign rx_ctrl    = (rx_type_i == TYP_CTRL) || (rx_type_i == TYP_MARK);
    assign tx_idle    = (tx_type_i == TYP_CTRL) && (tx_data_i == IDLE_WORD);

    // R7: strobe follows one cycle later
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_i |=> tx_valid_o);

    // R7: type stays aligned with its word
    p_type_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> (rx_type_o == $past(rx_type_i)));

    // R5: control words untouched on transmit
    p_ctrl_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ctrl) |=> (tx_data_o == $past(tx_data_i)));

    // R5: control words untouched on receive
    p_rx_ctrl_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_ctrl) |=> (rx_data_o == $past(rx_data_i)));

    // R6: bypass leaves payload unmodified
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && !scram_en) |=> (tx_data_o == $past(tx_data_i)));

    // R8: no strobe, no output, word held
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid_i |=> (!tx_valid_o && $stable(tx_data_o)));

    // R3: payload right after a marker word uses the seed keystream
    p_mark_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_type_i == TYP_MARK) ##1 (tx_valid_i && tx_is_data && scram_en)
        |=> (tx_data_o == ($past(tx_data_i) ^ SEED_KS)));

    // R4: payload right after the idle word uses the seed keystream
    p_idle_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_idle) ##1 (tx_valid_i && tx_is_data && scram_en)
        |=> (tx_data_o == ($past(tx_data_i) ^ SEED_KS)));

endmodule

bind wscr_link wscr_link_chk #(.SEED(SEED), .IDLE_WORD(IDLE_WORD)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scram_en  (scram_en),
    .tx_valid_i(tx_valid_i),
    .tx_type_i (tx_type_i),
    .tx_data_i (tx_data_i),
    .tx_valid_o(tx_valid_o),
    .tx_type_o (tx_type_o),
    .tx_data_o (tx_data_o),
    .rx_valid_i(rx_valid_i),
    .rx_type_i (rx_type_i),
    .rx_data_i (rx_data_i),
    .rx_valid_o(rx_valid_o),
    .rx_type_o (rx_type_o),
    .rx_data_o (rx_data_o)
);

// File: tb/test_wscr_link.sv
module test_wscr_link;

    localparam logic [31:0] IDLE = 32'hA5C3_3C5A;
    localparam int          WD_LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scram_en;
    logic        tx_valid_i, tx_valid_o, rx_valid_o;
    logic [1:0]  tx_type_i, tx_type_o, rx_type_o;
    logic [31:0] tx_data_i, tx_data_o, rx_data_o;

    int checks   = 0;
    int failures = 0;

    logic [6:0]  m_st;
    logic        en_b;
    logic        pend_v;
    logic [1:0]  pend_t;
    logic [31:0] pend_w;
    logic [31:0] last_tx;

    always #2 clk = ~clk;

    wscr_link i_wscr_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scram_en  (scram_en),
        .tx_valid_i(tx_valid_i),
        .tx_type_i (tx_type_i),
        .tx_data_i (tx_data_i),
        .tx_valid_o(tx_valid_o),
        .tx_type_o (tx_type_o),
        .tx_data_o (tx_data_o),
        .rx_valid_i(tx_valid_o),
        .rx_type_i (tx_type_o),
        .rx_data_i (tx_data_o),
        .rx_valid_o(rx_valid_o),
        .rx_type_o (rx_type_o),
        .rx_data_o (rx_data_o)
    );

    // bit-serial reference of the keystream (R2)
    function automatic logic [31:0] ref_word(input logic [6:0] s_in, output logic [6:0] s_out);
        logic [6:0]  s;
        logic [31:0] k;
        s = s_in;
        k = '0;
        for (int i = 0; i < 32; i++) begin
            k[31-i] = s[6];
            s = {s[5:0], s[6] ^ s[0]};
        end
        s_out = s;
        return k;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one word through the chain; checks tx now and rx for the previous word
    task automatic step(input logic v, input logic [1:0] t, input logic [31:0] w, input string tag);
        logic [31:0] exp_tx;
        logic [31:0] ks;
        logic [6:0]  ns;
        tx_valid_i = v;
        tx_type_i  = t;
        tx_data_i  = w;
        scram_en   = en_b;
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            exp_tx = w;
            if ((t == 2'b01 || t == 2'b10) && en_b) begin
                ks     = ref_word(m_st, ns);
                exp_tx = w ^ ks;
                m_st   = ns;
            end else if (t == 2'b11 || (t == 2'b00 && w == IDLE)) begin
                m_st = 7'h7F;
            end
            chk(tag, "R7 tx_valid", {31'd0, tx_valid_o}, 32'd1);
            chk(tag, "R7 tx_type", {30'd0, tx_type_o}, {30'd0, t});
            chk(tag, "tx_data", tx_data_o, exp_tx);
            last_tx = exp_tx;
        end else begin
            chk(tag, "R8 tx_valid low", {31'd0, tx_valid_o}, 32'd0);
            chk(tag, "R8 tx_data held", tx_data_o, last_tx);
        end
        if (pend_v) begin
            chk("R10", "rx_valid", {31'd0, rx_valid_o}, 32'd1);
            chk("R10", "rx_type", {30'd0, rx_type_o}, {30'd0, pend_t});
            chk("R10", "rx_data recovered", rx_data_o, pend_w);
        end else begin
            chk("R10", "rx_valid low", {31'd0, rx_valid_o}, 32'd0);
        end
        pend_v = v;
        pend_t = t;
        pend_w = w;
    endtask

    task automatic set_en(input logic v);
        step(1'b0, 2'b00, 32'd0, "R8");
        en_b = v;
    endtask

    task automatic t_reset();
        chk("R9", "tx_valid after reset", {31'd0, tx_valid_o}, 32'd0);
        chk("R9", "rx_valid after reset", {31'd0, rx_valid_o}, 32'd0);
        chk("R9", "tx_data after reset", tx_data_o, 32'd0);
        // first payload word uses the seed keystream (R9, R2)
        step(1'b1, 2'b01, 32'h0000_0000, "R9");
        step(1'b1, 2'b10, 32'hFFFF_FFFF, "R2");
    endtask

    task automatic t_data_run();
        for (int i = 0; i < 12; i++)
            step(1'b1, (i % 2 == 0) ? 2'b01 : 2'b10, 32'h1234_5678 * (i + 3), "R1");
    endtask

    task automatic t_marker();
        step(1'b1, 2'b11, 32'hDEAD_BEEF, "R3");
        step(1'b1, 2'b01, 32'h0F0F_0F0F, "R3");
        step(1'b1, 2'b11, 32'h0000_0001, "R3");
        step(1'b1, 2'b11, 32'h0000_0002, "R3");
        step(1'b1, 2'b10, 32'hCAFE_F00D, "R3");
    endtask

    task automatic t_idle_ctrl();
        step(1'b1, 2'b01, 32'h5555_AAAA, "R1");
        step(1'b1, 2'b00, IDLE, "R4");
        step(1'b1, 2'b01, 32'h0000_0000, "R4");
        step(1'b1, 2'b00, 32'h1111_2222, "R5");
        step(1'b1, 2'b10, 32'h0000_0000, "R4");
        step(1'b1, 2'b00, IDLE ^ 32'h1, "R4");
        step(1'b1, 2'b01, 32'h8000_0001, "R4");
    endtask

    task automatic t_bypass();
        set_en(1'b0);
        step(1'b1, 2'b01, 32'h0BAD_F00D, "R6");
        step(1'b1, 2'b10, 32'h1357_9BDF, "R6");
        step(1'b1, 2'b11, 32'h2468_ACE0, "R6");
        step(1'b1, 2'b01, 32'hFFFF_0000, "R6");
        set_en(1'b1);
        step(1'b1, 2'b01, 32'h0000_0000, "R6");
        step(1'b1, 2'b10, 32'h0000_0000, "R6");
    endtask

    task automatic t_gaps();
        step(1'b1, 2'b01, 32'h7777_7777, "R8");
        step(1'b0, 2'b01, 32'h9999_9999, "R8");
        step(1'b0, 2'b11, 32'h0000_0000, "R8");
        step(1'b1, 2'b10, 32'h7777_7777, "R8");
    endtask

    task automatic t_random_mix();
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            logic [31:0] w;
            r = $urandom;
            w = $urandom;
            if (r[9:7] == 3'd0) w = IDLE;
            if (i % 75 == 74) set_en(~en_b);
            step(r[2:0] != 3'd0, r[5:4], w, "R10");
        end
        step(1'b0, 2'b00, 32'd0, "R10");
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog cycles=%0d expected<%0d", WD_LIMIT, WD_LIMIT);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        scram_en   = 1'b1;
        tx_valid_i = 1'b0;
        tx_type_i  = 2'b00;
        tx_data_i  = 32'd0;
        en_b       = 1'b1;
        m_st       = 7'h7F;
        pend_v     = 1'b0;
        pend_t     = 2'b00;
        pend_w     = 32'd0;
        last_tx    = 32'd0;
        void'($urandom(32'd17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data_run();
        t_marker();
        t_idle_ctrl();
        t_bypass();
        t_gaps();
        t_random_mix();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule